// File: doc/BRIEF.md
# Dual-Width CPU Register File

This block is the general register store of a small CPU core that can run either as a legacy 16-bit machine or as a flat 24-bit machine. It holds seven named registers: the three general pairs, two index registers, the stack pointer and the program counter. Each of them is 24 bits wide. The top byte belongs only to the named register as a whole, and no operand code reaches it alone. A registered mode bit selects the width. In narrow mode the block acts as a plain 16-bit register set: reads come back zero-extended and writes and increments leave the top byte untouched. In wide mode every pair access and every step covers all 24 bits. The program counter can then address a flat 16 MB space directly, with no translation stage.

The core drives two combinational read ports, one write port and one step port for increment and decrement, each selected by a 4-bit operand code. An 8-bit accumulator and a flag register are included by default and are reached through the same codes. The instruction decoder, the ALU and the memory interface sit outside this block.

Top module: `wrf_top`

## Requirements
- R1: Operand codes 0 to 6 select the 24-bit registers BC, DE, HL, IX, IY, SP and PC in that order. Code 7 selects nothing: it reads as zero, and a write or step with code 7 changes no register.
- R2: While `mode_wide` is 1, a read of codes 0 to 6 returns all 24 bits, and a write with codes 0 to 6 stores all 24 bits of `w_data`.
- R3: While `mode_wide` is 0, a read of codes 0 to 6 returns bits 15:0 of the register, with bits 23:16 of the read data at zero.
- R4: While `mode_wide` is 0, a write with codes 0 to 6 stores `w_data[15:0]` and leaves bits 23:16 of the register unchanged. The preserved byte can be seen after switching to wide mode.
- R5: Byte codes B=8, C=9, D=10, E=11, H=12 and L=13 select bits 15:8 (even codes) or bits 7:0 (odd codes) of BC, DE or HL. A byte write stores `w_data[7:0]` into that byte only. A byte read returns it in bits 7:0 with all higher bits at zero, in either mode.
- R6: A step (`s_en`=1, `s_sel` 0 to 6) adds 1 when `s_down`=0 and subtracts 1 when `s_down`=1. In wide mode it wraps modulo 2^24. In narrow mode it wraps modulo 2^16 and the top byte does not change. Steps with codes 7 to 15 have no effect.
- R7: If the write port targets a register in the same cycle as the step port, the write takes effect and the step is dropped. A target here means the register's pair code or one of its byte codes.
- R8: Code 14 selects the 8-bit accumulator and code 15 the 8-bit flag register. Both are written from `w_data[7:0]` and read in bits 7:0, with zeros above.
- R9: A synchronous active-low reset clears every register, including the top bytes, and selects narrow mode.
- R10: A cycle with `mode_we`=1 loads `mode_in` into the mode bit at the clock edge. Accesses in that same cycle still use the old mode.
- R11: Read ports show the state before the clock edge. A write to the register being read in the same cycle is not forwarded, so the new value appears in the following cycle.
- R12: `pc_addr` gives the full 24-bit program counter in wide mode and its zero-extended low 16 bits in narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_we | input | 1 | Load the mode bit |
| mode_in | input | 1 | New mode: 1 = 24-bit, 0 = 16-bit |
| mode_wide | output | 1 | Current mode bit |
| w_en | input | 1 | Write port enable |
| w_sel | input | 4 | Write port operand code |
| w_data | input | 24 | Write data |
| s_en | input | 1 | Step port enable |
| s_sel | input | 4 | Step port operand code |
| s_down | input | 1 | Step direction: 1 = decrement |
| ra_sel | input | 4 | Read port A operand code |
| ra_data | output | 24 | Read port A data |
| rb_sel | input | 4 | Read port B operand code |
| rb_data | output | 24 | Read port B data |
| pc_addr | output | 24 | Program counter as a flat address |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, which give 16-bit narrow and 24-bit wide registers, with the accumulator and flag register present. That setting makes all sixteen operand codes live, including the two 8-bit extras and the empty code. Directed phases aim at the wrap boundaries FFFFFF and xxFFFF, top-byte preservation across mode switches, write-versus-step collisions, and same-cycle write and read on one register. A long random phase mixes modes, codes and port collisions. A behavioural model checks both read ports, the flat PC and the mode bit against the design on every cycle.

// File: rtl/wrf_pkg.sv
// Package: shared operand codes and decode helpers for the dual-width
// register file. Assumes a 4-bit operand code space, fully populated.
package wrf_pkg;

    localparam int SEL_W          = 4;
    localparam int NUM_WIDE       = 7;  // BC DE HL IX IY SP PC
    localparam int NUM_BYTE_PAIRS = 3;  // BC DE HL have byte halves
    localparam int PC_IDX         = 6;

    localparam logic [SEL_W-1:0] SEL_BC   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_DE   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_HL   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_IX   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_IY   = 4'd4;
    localparam logic [SEL_W-1:0] SEL_SP   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_PC   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_NONE = 4'd7;
    localparam logic [SEL_W-1:0] SEL_ACC  = 4'd14;
    localparam logic [SEL_W-1:0] SEL_FLG  = 4'd15;

    // True for codes that name a whole wide register.
    function automatic logic sel_is_wide(input logic [SEL_W-1:0] s);
        return (s[SEL_W-1] == 1'b0) && (s != SEL_NONE);
    endfunction

    // True for codes 8..13, the byte halves of BC/DE/HL.
    function automatic logic sel_is_byte(input logic [SEL_W-1:0] s);
        return s[SEL_W-1] && (s[2:1] != 2'b11);
    endfunction

    // Pair index of a byte code (valid only when sel_is_byte).
    function automatic logic [1:0] byte_pair(input logic [SEL_W-1:0] s);
        return s[2:1];
    endfunction

    // Even byte codes select the high half of the low word.
    function automatic logic byte_is_high(input logic [SEL_W-1:0] s);
        return ~s[0];
    endfunction

endpackage

// File: rtl/wrf_slot.sv
// Module: one 24-bit named register with its top-byte extension.
// Applies, in priority order, a full-register write, a byte write into the
// low word, or a +/-1 step. The mode input decides whether the top byte
// takes part. Assumes at most one of the write strobes is high at a time.
module wrf_slot #(
    parameter int BYTE_W = 8,
    localparam int LOW_W  = 2 * BYTE_W,
    localparam int FULL_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              wr_full_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [FULL_W-1:0] wr_data_i,
    input  logic              step_i,
    input  logic              step_down_i,
    output logic [FULL_W-1:0] q_o
);

    logic [FULL_W-1:0] q_r;
    logic [FULL_W-1:0] nxt;
    logic [LOW_W-1:0]  low_step;
    logic [FULL_W-1:0] full_step;
    logic              wr_any;

    assign wr_any = wr_full_i | wr_hi_i | wr_lo_i;

    // Stepped values for both widths; the narrow one wraps in the low word.
    always_comb begin
        if (step_down_i) begin
            low_step  = q_r[LOW_W-1:0] - 1'b1;
            full_step = q_r - 1'b1;
        end else begin
            low_step  = q_r[LOW_W-1:0] + 1'b1;
            full_step = q_r + 1'b1;
        end
    end

    // Next-state selection: writes beat steps, narrow mode keeps the top byte.
    always_comb begin
        nxt = q_r;
        if (wr_full_i) begin
            if (wide_i) nxt = wr_data_i;
            else        nxt[LOW_W-1:0] = wr_data_i[LOW_W-1:0];
        end else if (wr_hi_i) begin
            nxt[LOW_W-1:BYTE_W] = wr_data_i[BYTE_W-1:0];
        end else if (wr_lo_i) begin
            nxt[BYTE_W-1:0] = wr_data_i[BYTE_W-1:0];
        end else if (step_i) begin
            if (wide_i) nxt = full_step;
            else        nxt[LOW_W-1:0] = low_step;
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= nxt;
    end

    assign q_o = q_r;

    AST_NARROW_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> q_o[FULL_W-1:LOW_W] == $past(q_o[FULL_W-1:LOW_W])); // R4
    AST_WIDE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && step_i && !step_down_i && !wr_any) |=>
        q_o == FULL_W'($past(q_o) + 1'b1)); // R6
    AST_NARROW_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && step_i && step_down_i && !wr_any) |=>
        q_o[LOW_W-1:0] == LOW_W'($past(q_o[LOW_W-1:0]) - 1'b1)); // R6
    AST_SLOT_CLEARED: assert property (@(posedge clk)
        $rose(rst_n) |-> q_o == '0); // R9

endmodule

// File: rtl/wrf_byte_reg.sv
// Module: plain 8-bit register used for the accumulator and the flags.
// Loads on a write strobe and holds otherwise. Assumes a synchronous clear.
module wrf_byte_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] d_i,
    output logic [BYTE_W-1:0] q_o
);

    // Load-or-hold storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
    end

    AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o)); // R8

endmodule

// File: rtl/wrf_read_mux.sv
// Module: one read port. Turns an operand code into read data: a wide
// register in full or zero-extended form, one byte half of a pair, or
// the accumulator or flags. Unused codes read zero.
module wrf_read_mux #(
    parameter int BYTE_W = 8,
    localparam int LOW_W  = 2 * BYTE_W,
    localparam int FULL_W = 3 * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide_i,
    input  logic [wrf_pkg::SEL_W-1:0] sel_i,
    input  logic [FULL_W-1:0]         regs_i [wrf_pkg::NUM_WIDE],
    input  logic [BYTE_W-1:0]         acc_i,
    input  logic [BYTE_W-1:0]         flg_i,
    output logic [FULL_W-1:0]         rd_o
);
    import wrf_pkg::*;

    logic [FULL_W-1:0] wide_word;
    logic [FULL_W-1:0] pair_word;

    // Pick the wide register named by the code.
    always_comb begin
        wide_word = '0;
        for (int i = 0; i < NUM_WIDE; i++) begin
            if (sel_i == SEL_W'(i)) wide_word = regs_i[i];
        end
    end

    // Pick the pair that holds the addressed byte half.
    always_comb begin
        pair_word = '0;
        for (int i = 0; i < NUM_BYTE_PAIRS; i++) begin
            if (byte_pair(sel_i) == 2'(i)) pair_word = regs_i[i];
        end
    end

    // Shape the output to the access width.
    always_comb begin
        rd_o = '0;
        if (sel_is_wide(sel_i)) begin
            if (wide_i) rd_o = wide_word;
            else        rd_o[LOW_W-1:0] = wide_word[LOW_W-1:0];
        end else if (sel_is_byte(sel_i)) begin
            if (byte_is_high(sel_i)) rd_o[BYTE_W-1:0] = pair_word[LOW_W-1:BYTE_W];
            else                     rd_o[BYTE_W-1:0] = pair_word[BYTE_W-1:0];
        end else if (sel_i == SEL_ACC) begin
            rd_o[BYTE_W-1:0] = acc_i;
        end else if (sel_i == SEL_FLG) begin
            rd_o[BYTE_W-1:0] = flg_i;
        end
    end

    AST_NARROW_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> rd_o[FULL_W-1:LOW_W] == '0); // R3
    AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i[SEL_W-1] |-> rd_o[FULL_W-1:BYTE_W] == '0); // R5
    AST_EMPTY_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_NONE) |-> rd_o == '0); // R1

endmodule

// File: rtl/wrf_top.sv
// Module: dual-width register file top. Holds seven wide registers, an
// optional accumulator/flag pair and the mode bit. Decodes the write and
// step ports into per-register strobes and drives two read ports and the
// flat program-counter address. Reads are taken from current state
// without forwarding of same-cycle writes.
module wrf_top #(
    parameter int BYTE_W  = 8,
    parameter bit HAS_ACC = 1'b1,
    localparam int LOW_W  = 2 * BYTE_W,
    localparam int FULL_W = 3 * BYTE_W,
    localparam int NUM_RD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              mode_in,
    output logic              mode_wide,
    input  logic              w_en,
    input  logic [3:0]        w_sel,
    input  logic [FULL_W-1:0] w_data,
    input  logic              s_en,
    input  logic [3:0]        s_sel,
    input  logic              s_down,
    input  logic [3:0]        ra_sel,
    output logic [FULL_W-1:0] ra_data,
    input  logic [3:0]        rb_sel,
    output logic [FULL_W-1:0] rb_data,
    output logic [FULL_W-1:0] pc_addr
);
    import wrf_pkg::*;

    logic              mode_q;
    logic [FULL_W-1:0] regs [NUM_WIDE];
    logic [BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0] flg_q;
    logic [SEL_W-1:0]  rd_sel [NUM_RD];
    logic [FULL_W-1:0] rd_data [NUM_RD];

    // Width-mode bit, narrow after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (mode_we) mode_q <= mode_in;
    end

    assign mode_wide = mode_q;

    // Wide registers with their per-register write and step strobes.
    for (genvar i = 0; i < NUM_WIDE; i++) begin : g_slot
        logic wr_full, wr_hi, wr_lo, step;
        assign wr_full = w_en && (w_sel == SEL_W'(i));
        assign step    = s_en && (s_sel == SEL_W'(i));
        if (i < NUM_BYTE_PAIRS) begin : g_bytes
            assign wr_hi = w_en && sel_is_byte(w_sel) &&
                           (byte_pair(w_sel) == 2'(i)) && byte_is_high(w_sel);
            assign wr_lo = w_en && sel_is_byte(w_sel) &&
                           (byte_pair(w_sel) == 2'(i)) && !byte_is_high(w_sel);
        end else begin : g_nobytes
            assign wr_hi = 1'b0;
            assign wr_lo = 1'b0;
        end
        wrf_slot #(.BYTE_W(BYTE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wide_i     (mode_q),
            .wr_full_i  (wr_full),
            .wr_hi_i    (wr_hi),
            .wr_lo_i    (wr_lo),
            .wr_data_i  (w_data),
            .step_i     (step),
            .step_down_i(s_down),
            .q_o        (regs[i])
        );
    end

    // Optional accumulator and flag registers.
    if (HAS_ACC) begin : g_acc
        wrf_byte_reg #(.BYTE_W(BYTE_W)) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .we_i (w_en && (w_sel == SEL_ACC)),
            .d_i  (w_data[BYTE_W-1:0]),
            .q_o  (acc_q)
        );
        wrf_byte_reg #(.BYTE_W(BYTE_W)) u_flg (
            .clk  (clk),
            .rst_n(rst_n),
            .we_i (w_en && (w_sel == SEL_FLG)),
            .d_i  (w_data[BYTE_W-1:0]),
            .q_o  (flg_q)
        );
    end else begin : g_noacc
        assign acc_q = '0;
        assign flg_q = '0;
    end

    assign rd_sel[0] = ra_sel;
    assign rd_sel[1] = rb_sel;

    // Identical read ports.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        wrf_read_mux #(.BYTE_W(BYTE_W)) u_mux (
            .clk   (clk),
            .rst_n (rst_n),
            .wide_i(mode_q),
            .sel_i (rd_sel[p]),
            .regs_i(regs),
            .acc_i (acc_q),
            .flg_i (flg_q),
            .rd_o  (rd_data[p])
        );
    end

    assign ra_data = rd_data[0];
    assign rb_data = rd_data[1];

    // Flat fetch address, masked to the low word in narrow mode.
    always_comb begin
        pc_addr = '0;
        if (mode_q) pc_addr = regs[PC_IDX];
        else        pc_addr[LOW_W-1:0] = regs[PC_IDX][LOW_W-1:0];
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_wide == $past(mode_in)); // R10
    AST_MODE_NARROW_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> !mode_wide); // R9
    AST_PC_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wide |-> pc_addr[FULL_W-1:LOW_W] == '0); // R12

endmodule

// File: tb/wrf_top_tb_top.sv
// Bench: behavioural reference model compared with the design every cycle.
module wrf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0, mode_in = 1'b0;
    logic        mode_wide;
    logic        w_en = 1'b0;
    logic [3:0]  w_sel = '0;
    logic [23:0] w_data = '0;
    logic        s_en = 1'b0;
    logic [3:0]  s_sel = '0;
    logic        s_down = 1'b0;
    logic [3:0]  ra_sel = '0, rb_sel = '0;
    logic [23:0] ra_data, rb_data, pc_addr;

    int checks = 0;
    int errors = 0;
    string tag = "R9";

    // Reference state.
    logic [23:0] m [7];
    logic [7:0]  m_acc, m_flg;
    logic        m_wide;

    always #5 clk = ~clk;

    wrf_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .mode_wide(mode_wide), .w_en(w_en), .w_sel(w_sel), .w_data(w_data),
        .s_en(s_en), .s_sel(s_sel), .s_down(s_down),
        .ra_sel(ra_sel), .ra_data(ra_data), .rb_sel(rb_sel), .rb_data(rb_data),
        .pc_addr(pc_addr)
    );

    function automatic logic [23:0] exp_rd(input int code);
        logic [23:0] r;
        r = '0;
        if (code < 7)            r = m_wide ? m[code] : {8'h00, m[code][15:0]};
        else if (code >= 8 && code <= 13) begin
            if (code % 2 == 0)   r = {16'h0, m[(code - 8) / 2][15:8]};
            else                 r = {16'h0, m[(code - 8) / 2][7:0]};
        end
        else if (code == 14)     r = {16'h0, m_acc};
        else if (code == 15)     r = {16'h0, m_flg};
        return r;
    endfunction

    task automatic chk(input string what, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %06h expected %06h", tag, what, got, exp);
        end
    endtask

    // Model update for one clock edge, using the values driven this cycle.
    task automatic model_step();
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) m[i] = '0;
            m_acc = '0; m_flg = '0; m_wide = 1'b0;
            return;
        end
        for (int i = 0; i < 7; i++) begin
            int wc = int'(w_sel);
            bit hit_pair = w_en && (wc == i);
            bit hit_byte = w_en && (wc >= 8) && (wc <= 13) && ((wc - 8) / 2 == i);
            if (hit_pair) begin
                if (m_wide) m[i] = w_data;
                else        m[i][15:0] = w_data[15:0];
            end else if (hit_byte) begin
                if (wc % 2 == 0) m[i][15:8] = w_data[7:0];
                else             m[i][7:0]  = w_data[7:0];
            end else if (s_en && int'(s_sel) == i) begin
                if (m_wide) m[i] = s_down ? m[i] - 24'd1 : m[i] + 24'd1;
                else        m[i][15:0] = s_down ? m[i][15:0] - 16'd1 : m[i][15:0] + 16'd1;
            end
        end
        if (w_en && w_sel == 4'd14) m_acc = w_data[7:0];
        if (w_en && w_sel == 4'd15) m_flg = w_data[7:0];
        if (mode_we) m_wide = mode_in;
    endtask

    // Drive one cycle after the falling edge, compare, then advance the model.
    task automatic cyc(input bit we, input int ws, input logic [23:0] wd,
                       input bit se, input int ss, input bit sd,
                       input bit mwe, input bit mi, input int ra, input int rb);
        @(negedge clk);
        w_en = we; w_sel = 4'(ws); w_data = wd;
        s_en = se; s_sel = 4'(ss); s_down = sd;
        mode_we = mwe; mode_in = mi;
        ra_sel = 4'(ra); rb_sel = 4'(rb);
        #1;
        if (rst_n) begin
            chk("ra_data", ra_data, exp_rd(ra));
            chk("rb_data", rb_data, exp_rd(rb));
            chk("pc_addr", pc_addr, m_wide ? m[6] : {8'h00, m[6][15:0]});
            chk("mode_wide", {23'h0, mode_wide}, {23'h0, m_wide});
        end
        @(posedge clk);
        model_step();
    endtask

    task automatic rd(input int ra, input int rb);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, ra, rb);
    endtask

    task automatic set_mode(input bit w);
        cyc(0, 0, 0, 0, 0, 0, 1, w, 7, 7);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset clears everything, narrow mode
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        tag = "R9";
        for (int c = 0; c < 16; c += 2) rd(c, c + 1);

        tag = "R2";
        set_mode(1);
        cyc(1, 2, 24'hABCDEF, 0, 0, 0, 0, 0, 7, 7);
        rd(2, 6);

        tag = "R11";
        cyc(1, 0, 24'h123456, 0, 0, 0, 0, 0, 0, 0);   // old BC=0 expected
        rd(0, 0);

        tag = "R3";
        set_mode(0);
        rd(2, 0);

        tag = "R4";
        cyc(1, 2, 24'hFF1111, 0, 0, 0, 0, 0, 7, 7);
        set_mode(1);
        rd(2, 2);                                        // AB1111

        tag = "R5";
        cyc(1, 12, 24'h77775A, 0, 0, 0, 0, 0, 7, 7);
        cyc(1, 13, 24'h0000C3, 0, 0, 0, 0, 0, 7, 7);
        rd(12, 13);
        rd(2, 8);
        set_mode(0);
        cyc(1, 9, 24'h000099, 0, 0, 0, 0, 0, 7, 7);
        rd(9, 0);

        tag = "R6";
        set_mode(1);
        cyc(1, 5, 24'hFFFFFF, 0, 0, 0, 0, 0, 7, 7);
        cyc(0, 0, 0, 1, 5, 0, 0, 0, 5, 5);
        cyc(0, 0, 0, 1, 5, 1, 0, 0, 5, 5);
        rd(5, 5);
        cyc(1, 6, 24'h12FFFF, 0, 0, 0, 0, 0, 7, 7);
        set_mode(0);
        cyc(0, 0, 0, 1, 6, 0, 0, 0, 6, 6);
        cyc(0, 0, 0, 1, 9, 0, 0, 0, 0, 9);
        cyc(0, 0, 0, 1, 7, 0, 0, 0, 0, 6);
        set_mode(1);
        rd(6, 0);                                        // PC=120000

        tag = "R7";
        cyc(1, 2, 24'h010203, 1, 2, 0, 0, 0, 7, 7);
        cyc(1, 13, 24'h0000EE, 1, 2, 1, 0, 0, 2, 7);
        rd(2, 13);

        tag = "R8";
        cyc(1, 14, 24'hFFFF3C, 0, 0, 0, 0, 0, 7, 7);
        cyc(1, 15, 24'h0000A5, 0, 0, 0, 0, 0, 14, 15);
        rd(14, 15);

        tag = "R1";
        cyc(1, 7, 24'hDEAD00, 1, 7, 0, 0, 0, 7, 3);
        for (int c = 0; c < 7; c++) rd(c, 7);

        tag = "R10";
        cyc(1, 4, 24'hBBCCDD, 0, 0, 0, 1, 0, 7, 7);      // written in wide mode
        set_mode(1);
        rd(4, 4);

        tag = "R12";
        cyc(1, 6, 24'hFEDCBA, 0, 0, 0, 0, 0, 6, 6);
        rd(6, 6);
        set_mode(0);
        rd(6, 6);

        tag = "R6 random mix";
        for (int n = 0; n < 4000; n++) begin
            logic [23:0] d;
            int ws;
            d = 24'($urandom);
            ws = int'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) d = ($urandom_range(0, 1) == 1) ? 24'hFFFFFF : 24'h00FFFF;
            cyc($urandom_range(0, 2) != 0, ws, d,
                $urandom_range(0, 1) == 1, int'($urandom_range(0, 15)), $urandom_range(0, 1) == 1,
                $urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1,
                int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0) ? ws : int'($urandom_range(0, 15)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule